// File: doc/BRIEF.md
# Interrupt Enable, Force and Class Register Bank

This block is one 32-line slice of an interrupt controller. It sits between 32 raw interrupt request lines and two processors: a main CPU and a coprocessor. Each processor has its own enable mask and its own class mask. The class mask sends each enabled line either to that processor's normal interrupt output or to its fast interrupt output. A software force register lets firmware raise any line by itself. Clearing a force bit acknowledges a software-raised interrupt, and setting it again re-triggers the line.

Software reaches the bank through a simple 32-bit register port. A write is one cycle with a strobe, and reads are combinational. The force register and both enable registers each have three addresses: a full-write address, a set alias and a clear alias. Firmware can therefore change single bits without a read-modify-write. Global interrupt number n belongs to slice (n-32)/32, at bit (n-32) mod 32 of every register. Choosing the slice happens outside this block.

Top module: `irq_route_bank`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, every force, enable and class bit is 0 and all four interrupt outputs are low.
- R2: A line is pending when its raw input or its force bit is 1. `cpu_irq` is 1 when some line is pending, CPU-enabled and has CPU class bit 0.
- R3: `cpu_fiq` is 1 when some line is pending, CPU-enabled and has CPU class bit 1.
- R4: `cop_irq` and `cop_fiq` follow the rules of R2 and R3, using the coprocessor enable register and the coprocessor class register.
- R5: A write to a full-write offset replaces the whole register: force 0x14, CPU enable 0x20, CPU class 0x2C, coprocessor enable 0x30, coprocessor class 0x3C.
- R6: A write to a set alias (force 0x18, CPU enable 0x24, coprocessor enable 0x34) sets each bit written as 1 and leaves the bits written as 0 unchanged.
- R7: A write to a clear alias (force 0x1C, CPU enable 0x28, coprocessor enable 0x38) clears each bit written as 1 and leaves the bits written as 0 unchanged. Clearing a force bit removes that forced request.
- R8: A read of a set or clear alias returns the present value of the register behind it. A read of a full-write offset returns that register.
- R9: A read of offset 0x08 returns the lines that are pending, CPU-enabled and have CPU class bit 1. A write to 0x08 changes nothing.
- R10: Any offset not listed in R5 to R9 reads as 0, and a write to it changes nothing.
- R11: The interrupt outputs are registered. A register write or a raw input change at one clock edge shows on the outputs at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 32 | Raw interrupt request lines, synchronous to clk |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_irq | output | 1 | CPU normal interrupt |
| cpu_fiq | output | 1 | CPU fast interrupt |
| cop_irq | output | 1 | Coprocessor normal interrupt |
| cop_fiq | output | 1 | Coprocessor fast interrupt |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are known whenever `bus_wr` is high. They also assume that `irq_raw` is a clean synchronous vector with no unknown bits, because the pending set and every output are computed from it. The stimulus drives every input just after the falling edge from a defined value, so the inputs are stable and known at each rising edge. Offsets are drawn from a list that mixes mapped offsets, alias offsets, the read-only fast view and unmapped holes. Write data includes single-bit patterns as well as wide patterns.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned LINES  = 32;
  localparam int unsigned ADDR_W = 8;

  // Byte offsets the software map depends on.
  localparam logic [ADDR_W-1:0] OFS_FAST_VIEW = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FRC       = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FRC_SET   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_FRC_CLR   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CEN       = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CEN_SET   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CEN_CLR   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CCLS      = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_PEN       = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PEN_SET   = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PEN_CLR   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_PCLS      = 8'h3C;

  localparam int unsigned TARGETS = 2;

  // Next value of a register that has full, set and clear write ports.
  function automatic logic [LINES-1:0] reg_next(
    input logic [LINES-1:0] cur,
    input logic [LINES-1:0] wdata,
    input logic             full,
    input logic             set,
    input logic             clr
  );
    if (full)     return wdata;
    else if (set) return cur | wdata;
    else if (clr) return cur & ~wdata;
    else          return cur;
  endfunction

  // Lines that are pending, enabled and in the requested class.
  function automatic logic [LINES-1:0] routed(
    input logic [LINES-1:0] pend,
    input logic [LINES-1:0] en,
    input logic [LINES-1:0] cls,
    input logic             want_fast
  );
    return pend & en & (want_fast ? cls : ~cls);
  endfunction
endpackage

// File: rtl/irq_route_wreg.sv
module irq_route_wreg
  import irq_route_pkg::*;
#(
  parameter int unsigned W = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_full,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = reg_next(q, wdata, wr_full, wr_set, wr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/irq_route_target.sv
module irq_route_target
  import irq_route_pkg::*;
#(
  parameter int unsigned W = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend,
  input  logic [W-1:0] en,
  input  logic [W-1:0] cls,
  output logic         irq_o,
  output logic         fiq_o
);
  logic [W-1:0] slow_hits;
  logic [W-1:0] fast_hits;

  always_comb begin
    slow_hits = routed(pend, en, cls, 1'b0);
    fast_hits = routed(pend, en, cls, 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |slow_hits;
      fiq_o <= |fast_hits;
    end
  end
endmodule

// File: rtl/irq_route_bank.sv
module irq_route_bank
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_LINES = LINES,
  parameter int unsigned AW        = ADDR_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_raw,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [NUM_LINES-1:0] bus_wdata,
  output logic [NUM_LINES-1:0] bus_rdata,
  output logic                 cpu_irq,
  output logic                 cpu_fiq,
  output logic                 cop_irq,
  output logic                 cop_fiq
);
  // Decoded write events, named so the checker can see them.
  logic wr_frc, wr_frc_set, wr_frc_clr;
  logic wr_cen, wr_cen_set, wr_cen_clr, wr_ccls;
  logic wr_pen, wr_pen_set, wr_pen_clr, wr_pcls;
  logic wr_fast_view, wr_unmapped;

  logic [NUM_LINES-1:0] frc_q, cen_q, ccls_q, pen_q, pcls_q;
  logic [NUM_LINES-1:0] pend, fast_view;

  always_comb begin
    wr_frc       = bus_wr && (bus_addr == OFS_FRC);
    wr_frc_set   = bus_wr && (bus_addr == OFS_FRC_SET);
    wr_frc_clr   = bus_wr && (bus_addr == OFS_FRC_CLR);
    wr_cen       = bus_wr && (bus_addr == OFS_CEN);
    wr_cen_set   = bus_wr && (bus_addr == OFS_CEN_SET);
    wr_cen_clr   = bus_wr && (bus_addr == OFS_CEN_CLR);
    wr_ccls      = bus_wr && (bus_addr == OFS_CCLS);
    wr_pen       = bus_wr && (bus_addr == OFS_PEN);
    wr_pen_set   = bus_wr && (bus_addr == OFS_PEN_SET);
    wr_pen_clr   = bus_wr && (bus_addr == OFS_PEN_CLR);
    wr_pcls      = bus_wr && (bus_addr == OFS_PCLS);
    wr_fast_view = bus_wr && (bus_addr == OFS_FAST_VIEW);
    wr_unmapped  = bus_wr && !(wr_frc || wr_frc_set || wr_frc_clr ||
                               wr_cen || wr_cen_set || wr_cen_clr || wr_ccls ||
                               wr_pen || wr_pen_set || wr_pen_clr || wr_pcls ||
                               wr_fast_view);
  end

  irq_route_wreg #(.W(NUM_LINES)) u_frc (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_frc), .wr_set(wr_frc_set),
    .wr_clr(wr_frc_clr), .wdata(bus_wdata), .q(frc_q));

  irq_route_wreg #(.W(NUM_LINES)) u_cen (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_cen), .wr_set(wr_cen_set),
    .wr_clr(wr_cen_clr), .wdata(bus_wdata), .q(cen_q));

  irq_route_wreg #(.W(NUM_LINES)) u_ccls (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_ccls), .wr_set(1'b0),
    .wr_clr(1'b0), .wdata(bus_wdata), .q(ccls_q));

  irq_route_wreg #(.W(NUM_LINES)) u_pen (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_pen), .wr_set(wr_pen_set),
    .wr_clr(wr_pen_clr), .wdata(bus_wdata), .q(pen_q));

  irq_route_wreg #(.W(NUM_LINES)) u_pcls (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_pcls), .wr_set(1'b0),
    .wr_clr(1'b0), .wdata(bus_wdata), .q(pcls_q));

  always_comb begin
    pend      = irq_raw | frc_q;
    fast_view = routed(pend, cen_q, ccls_q, 1'b1);
  end

  // Read mux: aliases return the register behind them.
  always_comb begin
    unique case (bus_addr)
      OFS_FAST_VIEW:                     bus_rdata = fast_view;
      OFS_FRC, OFS_FRC_SET, OFS_FRC_CLR: bus_rdata = frc_q;
      OFS_CEN, OFS_CEN_SET, OFS_CEN_CLR: bus_rdata = cen_q;
      OFS_CCLS:                          bus_rdata = ccls_q;
      OFS_PEN, OFS_PEN_SET, OFS_PEN_CLR: bus_rdata = pen_q;
      OFS_PCLS:                          bus_rdata = pcls_q;
      default:                           bus_rdata = '0;
    endcase
  end

  // One output stage per interrupt target: 0 = CPU, 1 = coprocessor.
  logic [NUM_LINES-1:0] tgt_en  [TARGETS];
  logic [NUM_LINES-1:0] tgt_cls [TARGETS];
  logic [TARGETS-1:0]   tgt_irq, tgt_fiq;

  always_comb begin
    tgt_en[0]  = cen_q;
    tgt_cls[0] = ccls_q;
    tgt_en[1]  = pen_q;
    tgt_cls[1] = pcls_q;
  end

  for (genvar t = 0; t < TARGETS; t++) begin : g_tgt
    irq_route_target #(.W(NUM_LINES)) u_out (
      .clk(clk), .rst_n(rst_n), .pend(pend), .en(tgt_en[t]),
      .cls(tgt_cls[t]), .irq_o(tgt_irq[t]), .fiq_o(tgt_fiq[t]));
  end

  assign cpu_irq = tgt_irq[0];
  assign cpu_fiq = tgt_fiq[0];
  assign cop_irq = tgt_irq[1];
  assign cop_fiq = tgt_fiq[1];
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] irq_raw,
  input logic [W-1:0] bus_wdata,
  input logic         wr_frc_set,
  input logic         wr_frc_clr,
  input logic         wr_cen_set,
  input logic         wr_cen_clr,
  input logic         wr_fast_view,
  input logic         wr_unmapped,
  input logic [W-1:0] frc_q,
  input logic [W-1:0] cen_q,
  input logic [W-1:0] ccls_q,
  input logic [W-1:0] pen_q,
  input logic [W-1:0] pcls_q,
  input logic         cpu_irq,
  input logic         cpu_fiq,
  input logic         cop_irq,
  input logic         cop_fiq
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!cpu_irq && !cpu_fiq && !cop_irq && !cop_fiq &&
                                   frc_q == '0 && cen_q == '0 && pen_q == '0);
    end
  end

  a_r2_irq_needs_enabled_pending: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_irq) |-> $past(|((irq_raw | frc_q) & cen_q)));

  a_r3_fiq_needs_fast_class: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_fiq |-> $past(|((irq_raw | frc_q) & cen_q & ccls_q)));

  a_r4_cop_fiq_needs_class: assert property (@(posedge clk) disable iff (!rst_n)
    cop_fiq |-> $past(|((irq_raw | frc_q) & pen_q & pcls_q)));

  a_r6_force_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frc_set |=> ((frc_q & $past(bus_wdata)) == $past(bus_wdata)) &&
                   ((frc_q & ~$past(bus_wdata)) == ($past(frc_q) & ~$past(bus_wdata))));

  a_r6_enable_set_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cen_set |=> ((cen_q & $past(bus_wdata)) == $past(bus_wdata)) &&
                   ((cen_q & ~$past(bus_wdata)) == ($past(cen_q) & ~$past(bus_wdata))));

  a_r7_force_clear_acks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_frc_clr |=> ((frc_q & $past(bus_wdata)) == '0) &&
                   ((frc_q & ~$past(bus_wdata)) == ($past(frc_q) & ~$past(bus_wdata))));

  a_r7_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cen_clr |=> (cen_q & $past(bus_wdata)) == '0);

  a_r9_fast_view_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fast_view |=> $stable(frc_q) && $stable(cen_q) && $stable(ccls_q) &&
                     $stable(pen_q) && $stable(pcls_q));

  a_r10_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(frc_q) && $stable(cen_q) && $stable(ccls_q) &&
                    $stable(pen_q) && $stable(pcls_q));
endmodule

bind irq_route_bank irq_route_chk #(.W(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .bus_wdata(bus_wdata),
  .wr_frc_set(wr_frc_set), .wr_frc_clr(wr_frc_clr),
  .wr_cen_set(wr_cen_set), .wr_cen_clr(wr_cen_clr),
  .wr_fast_view(wr_fast_view), .wr_unmapped(wr_unmapped),
  .frc_q(frc_q), .cen_q(cen_q), .ccls_q(ccls_q), .pen_q(pen_q), .pcls_q(pcls_q),
  .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq));

// File: tb/irq_route_bank_tb_top.sv
`timescale 1ns/1ps
module irq_route_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_raw = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

  always #2 clk = ~clk;   // 250 MHz

  irq_route_bank dut_i (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_raw), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq));

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit run_cmp  = 1'b0;

  // Behavioural model state.
  bit [31:0] m_force, m_cen, m_ccls, m_pen, m_pcls;
  bit        e_cirq, e_cfiq, e_pirq, e_pfiq;

  function automatic bit any_hit(bit [31:0] p, bit [31:0] en, bit [31:0] cls, bit fast);
    for (int i = 0; i < 32; i++)
      if (p[i] && en[i] && (cls[i] == fast)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit [31:0] model_read(bit [7:0] a);
    bit [31:0] p;
    p = irq_raw | m_force;
    case (a)
      8'h08: return p & m_cen & m_ccls;
      8'h14, 8'h18, 8'h1C: return m_force;
      8'h20, 8'h24, 8'h28: return m_cen;
      8'h2C: return m_ccls;
      8'h30, 8'h34, 8'h38: return m_pen;
      8'h3C: return m_pcls;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(bit [7:0] a);
    case (a)
      8'h08: return "R9";
      8'h18, 8'h1C, 8'h24, 8'h28, 8'h34, 8'h38: return "R8";
      8'h14, 8'h20, 8'h2C, 8'h30, 8'h3C: return "R5";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] p;
    if (!rst_n) begin
      m_force = '0; m_cen = '0; m_ccls = '0; m_pen = '0; m_pcls = '0;
      e_cirq = 0; e_cfiq = 0; e_pirq = 0; e_pfiq = 0;
    end else begin
      p = irq_raw | m_force;
      e_cirq = any_hit(p, m_cen, m_ccls, 1'b0);
      e_cfiq = any_hit(p, m_cen, m_ccls, 1'b1);
      e_pirq = any_hit(p, m_pen, m_pcls, 1'b0);
      e_pfiq = any_hit(p, m_pen, m_pcls, 1'b1);
      if (bus_wr) begin
        case (bus_addr)
          8'h14: m_force = bus_wdata;
          8'h18: m_force = m_force | bus_wdata;
          8'h1C: m_force = m_force & ~bus_wdata;
          8'h20: m_cen = bus_wdata;
          8'h24: m_cen = m_cen | bus_wdata;
          8'h28: m_cen = m_cen & ~bus_wdata;
          8'h2C: m_ccls = bus_wdata;
          8'h30: m_pen = bus_wdata;
          8'h34: m_pen = m_pen | bus_wdata;
          8'h38: m_pen = m_pen & ~bus_wdata;
          8'h3C: m_pcls = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare on every falling edge, half a cycle away from the active edge.
  always @(negedge clk) begin
    if (run_cmp && rst_n && !done) begin
      check("R2 R11", "cpu_irq", {31'b0, cpu_irq}, {31'b0, e_cirq});
      check("R3 R11", "cpu_fiq", {31'b0, cpu_fiq}, {31'b0, e_cfiq});
      check("R4 R11", "cop_irq", {31'b0, cop_irq}, {31'b0, e_pirq});
      check("R4 R11", "cop_fiq", {31'b0, cop_fiq}, {31'b0, e_pfiq});
      check(read_tag(bus_addr), "bus_rdata", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic drive(bit wr, bit [7:0] a, bit [31:0] d, bit [31:0] raw);
    @(negedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; irq_raw = raw;
  endtask

  task automatic read_at(bit [7:0] a);
    drive(1'b0, a, 32'h0, irq_raw);
  endtask

  localparam bit [7:0] ADDRS [16] = '{8'h08, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24,
    8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h00, 8'h04, 8'h40, 8'h2D};

  initial begin
    // R1: reset state observed while reset is held.
    repeat (3) @(negedge clk);
    check("R1", "cpu_irq in reset", {31'b0, cpu_irq}, 32'h0);
    check("R1", "cop_fiq in reset", {31'b0, cop_fiq}, 32'h0);
    #1 rst_n = 1'b1;
    bus_addr = 8'h20;
    @(negedge clk);
    check("R1", "CPU enable after reset", bus_rdata, 32'h0);
    run_cmp = 1'b1;

    // R2: raw line enabled in normal class.
    drive(1, 8'h20, 32'h0000_0010, 32'h0);
    drive(0, 8'h20, 32'h0, 32'h0000_0010);
    drive(0, 8'h20, 32'h0, 32'h0000_0010);
    // R3: move that line to fast class, then check fast view (R9).
    drive(1, 8'h2C, 32'h0000_0010, 32'h0000_0010);
    read_at(8'h08);
    // R9: write to the fast view leaves state unchanged.
    drive(1, 8'h08, 32'hFFFF_FFFF, 32'h0);
    read_at(8'h2C);
    // R6: force-set re-triggers a line, R7: force-clear acknowledges it.
    drive(1, 8'h18, 32'h8000_0001, 32'h0);
    read_at(8'h14);
    drive(1, 8'h24, 32'h8000_0000, 32'h0);
    drive(1, 8'h1C, 32'h0000_0001, 32'h0);
    read_at(8'h1C);
    // R7: enable clear alias touches only ones.
    drive(1, 8'h28, 32'h0000_0010, 32'h0);
    read_at(8'h24);
    // R4: coprocessor path.
    drive(1, 8'h34, 32'hF000_0000, 32'h0);
    drive(1, 8'h3C, 32'h4000_0000, 32'h6000_0000);
    drive(0, 8'h30, 32'h0, 32'h0);
    // R10: unmapped offsets.
    drive(1, 8'h40, 32'hFFFF_FFFF, 32'h0);
    read_at(8'h04);
    read_at(8'h14);

    // Mixed traffic.
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] d;
      case ($urandom_range(0, 2))
        0: d = 32'h1 << $urandom_range(0, 31);
        1: d = $urandom;
        default: d = $urandom & $urandom;
      endcase
      drive($urandom_range(0, 2) != 0, ADDRS[$urandom_range(0, 15)], d,
            ($urandom_range(0, 3) == 0) ? $urandom : (32'h1 << $urandom_range(0, 31)));
    end
    drive(0, 8'h00, 32'h0, 32'h0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule